// File: doc/BRIEF.md
# Asymmetric Phase Clock Prescaler

This block derives a slow sampling clock from the system clock. Its high time and its low time are programmed on their own: a 5-bit field sets the high time and a 3-bit field sets the low time, each counted in system clock cycles. Both phases are timed by one shared down counter. A zero test on that counter ends the high phase. A narrow equality test ends the low phase: it compares the counter's low bits with the bit-inverted low field.

Alongside the divided clock, the block gives a one-cycle strobe at every rising edge of that clock. Downstream logic in the system clock domain can use the strobe as a clock-enable. A legacy select input is accepted only so that older control words still fit, and it does nothing. The stream style does not apply here: the block has no data path, so every pin is a plain control or status level and there is no valid/ready handshake.

Top module: `phase_clock_divider`

## Requirements
- R1: With high field H (0 to 31), every high phase of `div_clk` lasts exactly H+1 system clock cycles.
- R2: With low field L (0 to 7), every low phase of `div_clk` between two high phases lasts exactly L+1 system clock cycles.
- R3: `rise_strobe` is 1 for exactly one cycle, which is the first cycle of each high phase. At all other times it is 0.
- R4: While `rst_n` is low, `div_clk` and `rise_strobe` are both 0.
- R5: While `enable` is low, `div_clk` is 0. After the first clock edge at which `enable` is sampled high, `div_clk` is 1 and a high phase begins.
- R6: `legacy_sel` has no effect. For the same fields, high and low widths are identical whether it is 0, 1 or toggling.
- R7: The fields are captured when each high phase starts. A change made during a period first affects the period that follows.
- R8: A high field of 19 and a low field of 7 give a period of 28 cycles: 20 high and 8 low.
- R9: If `enable` is dropped in the middle of a period, `div_clk` is 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider when high |
| hi_count | input | HI_W (5) | High phase length minus one |
| lo_count | input | LO_W (3) | Low phase length minus one |
| legacy_sel | input | 1 | Legacy select, ignored |
| div_clk | output | 1 | Divided clock |
| rise_strobe | output | 1 | One-cycle pulse at each rising edge of div_clk |

## Verification
The bench builds the block with its default widths: HI_W of 5 and LO_W of 3. At these widths the whole field space is only 256 pairs, so every high and low width the block can produce is measured. That includes the extreme pairs 0/0 and 31/7, and the wrap of the counter from zero to all ones at the start of each low phase. Directed runs cover a field change in the middle of a period, dropping enable in the middle of a phase, and toggling the legacy bit.

// File: rtl/phase_div_pkg.sv
package phase_div_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_t;
endpackage

// File: rtl/phase_down_counter.sv
module phase_down_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  // Decrements every cycle and wraps from zero to all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (hold)   count <= '0;
    else if (load)   count <= load_val;
    else             count <= count - 1'b1;
  end

  // R5: holding keeps the counter at its rest point
  assert_hold_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0));
endmodule

// File: rtl/phase_end_detect.sv
module phase_end_detect #(
  parameter int HW = 5,
  parameter int LW = 3
) (
  input  logic [HW-1:0] count,
  input  logic [LW-1:0] lo_field,
  output logic          hi_done,
  output logic          lo_done
);
  // The low phase starts at all ones. Counting down, the low LW bits
  // first equal ~L after exactly L steps.
  assign hi_done = (count == '0);
  assign lo_done = (count[LW-1:0] == ~lo_field);
endmodule

// File: rtl/phase_field_capture.sv
module phase_field_capture #(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [LW-1:0] field_in,
  output logic [LW-1:0] field_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    field_q <= '0;
    else if (take) field_q <= field_in;
  end

  // R7: the held field moves only when a new period starts
  assert_field_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(field_q));
endmodule

// File: rtl/phase_clock_divider.sv
module phase_clock_divider
  import phase_div_pkg::*;
#(
  parameter int HI_W = 5,
  parameter int LO_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [HI_W-1:0] hi_count,
  input  logic [LO_W-1:0] lo_count,
  input  logic            legacy_sel,
  output logic            div_clk,
  output logic            rise_strobe
);
  phase_t            state;
  logic [HI_W-1:0]   count;
  logic [LO_W-1:0]   lo_held;
  logic              hi_done, lo_done, start_high;

  assign start_high = enable &&
                      ((state == PH_IDLE) || ((state == PH_LOW) && lo_done));

  phase_down_counter #(.W(HI_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold(!enable), .load(start_high),
    .load_val(hi_count), .count(count)
  );

  phase_field_capture #(.LW(LO_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(start_high),
    .field_in(lo_count), .field_q(lo_held)
  );

  phase_end_detect #(.HW(HI_W), .LW(LO_W)) u_det (
    .count(count), .lo_field(lo_held), .hi_done(hi_done), .lo_done(lo_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= PH_IDLE;
      div_clk     <= 1'b0;
      rise_strobe <= 1'b0;
    end else begin
      rise_strobe <= 1'b0;
      if (!enable) begin
        state   <= PH_IDLE;
        div_clk <= 1'b0;
      end else if (start_high) begin
        state       <= PH_HIGH;
        div_clk     <= 1'b1;
        rise_strobe <= 1'b1;
      end else if ((state == PH_HIGH) && hi_done) begin
        state   <= PH_LOW;
        div_clk <= 1'b0;
      end
    end
  end

  assert_strobe_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk) |-> rise_strobe);
  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_strobe |=> !rise_strobe);
  assert_disabled_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !div_clk);
  assert_high_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_clk && hi_done && enable && !start_high) |=> !div_clk);
  assert_low_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PH_HIGH) && hi_done && enable) |=> (&count));
  assert_legacy_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(legacy_sel) && (state == PH_HIGH) && !hi_done && enable) |=> div_clk);
endmodule

// File: tb/phase_clock_divider_test.sv
module phase_clock_divider_test;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, legacy_sel = 1'b0;
  logic [4:0] hi_count = '0;
  logic [2:0] lo_count = '0;
  logic div_clk, rise_strobe;
  int checks = 0, fails = 0;
  bit toggle_leg = 1'b0;

  always #5 clk = ~clk;

  phase_clock_divider uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hi_count(hi_count),
    .lo_count(lo_count), .legacy_sel(legacy_sel),
    .div_clk(div_clk), .rise_strobe(rise_strobe)
  );

  always @(negedge clk) if (toggle_leg) legacy_sel <= ~legacy_sel;

  // {high field, low field, legacy, expected high width, expected low width}
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{19, 7, 0, 20, 8}, '{0, 0, 0, 1, 1}, '{31, 7, 1, 32, 8},
    '{11, 7, 1, 12, 8}, '{7, 7, 0, 8, 8}, '{31, 0, 0, 32, 1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Restart the divider and measure the first high phase and the following low phase.
  task automatic measure(input int h, input int l, input bit leg,
                         output int hw, output int lw, output int strb_bad);
    @(negedge clk);
    enable = 1'b0; hi_count = 5'(h); lo_count = 3'(l); legacy_sel = leg;
    @(negedge clk);
    enable = 1'b1;
    hw = 0; lw = 0; strb_bad = 0;
    @(negedge clk);
    if (!rise_strobe) strb_bad++;
    while (div_clk && hw < 100) begin
      hw++;
      if (hw > 1 && rise_strobe) strb_bad++;
      @(negedge clk);
    end
    while (!div_clk && lw < 100) begin
      lw++;
      if (rise_strobe) strb_bad++;
      @(negedge clk);
    end
    if (!rise_strobe) strb_bad++;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hw, lw, sb;
    // R4 reset state
    repeat (3) @(negedge clk);
    chk(div_clk == 1'b0 && rise_strobe == 1'b0, "R4", int'(div_clk), 0);
    enable = 1'b1;
    @(negedge clk);
    chk(div_clk == 1'b0, "R4 enable during reset", int'(div_clk), 0);
    enable = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(div_clk == 1'b0, "R5 idle while disabled", int'(div_clk), 0);

    // table walk: R1 R2 R3 R6 R8
    for (int i = 0; i < NV; i++) begin
      measure(VEC[i][0], VEC[i][1], VEC[i][2] != 0, hw, lw, sb);
      chk(hw == VEC[i][3], "R1 table high width", hw, VEC[i][3]);
      chk(lw == VEC[i][4], "R2 table low width", lw, VEC[i][4]);
      chk(sb == 0, "R3 table strobe", sb, 0);
    end
    measure(19, 7, 1'b0, hw, lw, sb);
    chk(hw + lw == 28, "R8 period 28", hw + lw, 28);

    // full sweep of every field pair: R1 R2 R3
    for (int h = 0; h < 32; h++) begin
      for (int l = 0; l < 8; l++) begin
        measure(h, l, 1'b0, hw, lw, sb);
        chk(hw == h + 1, "R1 sweep high width", hw, h + 1);
        chk(lw == l + 1, "R2 sweep low width", lw, l + 1);
        chk(sb == 0, "R3 sweep strobe", sb, 0);
      end
    end

    // R6: a toggling legacy bit changes nothing
    toggle_leg = 1'b1;
    measure(13, 5, 1'b0, hw, lw, sb);
    toggle_leg = 1'b0;
    chk(hw == 14, "R6 toggled legacy high", hw, 14);
    chk(lw == 6, "R6 toggled legacy low", lw, 6);

    // R5: first high phase comes right after the first enabled edge
    @(negedge clk); enable = 1'b0; hi_count = 5'd2; lo_count = 3'd1;
    @(negedge clk);
    chk(div_clk == 1'b0, "R5 low before enable", int'(div_clk), 0);
    enable = 1'b1;
    @(negedge clk);
    chk(div_clk == 1'b1 && rise_strobe == 1'b1, "R5 high after enable", int'(div_clk), 1);

    // R7: change the fields during a high phase
    @(negedge clk); enable = 1'b0; hi_count = 5'd3; lo_count = 3'd2;
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    hi_count = 5'd10; lo_count = 3'd5;
    hw = 0; lw = 0;
    while (div_clk && hw < 100) begin hw++; @(negedge clk); end
    while (!div_clk && lw < 100) begin lw++; @(negedge clk); end
    chk(hw == 4, "R7 current high keeps old field", hw, 4);
    chk(lw == 3, "R7 current low keeps old field", lw, 3);
    hw = 0; lw = 0;
    while (div_clk && hw < 100) begin hw++; @(negedge clk); end
    while (!div_clk && lw < 100) begin lw++; @(negedge clk); end
    chk(hw == 11, "R7 next high uses new field", hw, 11);
    chk(lw == 6, "R7 next low uses new field", lw, 6);

    // R9: drop enable inside a high phase
    hi_count = 5'd20;
    repeat (3) @(negedge clk);
    chk(div_clk == 1'b1, "R9 high before drop", int'(div_clk), 1);
    enable = 1'b0;
    @(negedge clk);
    chk(div_clk == 1'b0 && rise_strobe == 1'b0, "R9 low after drop", int'(div_clk), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule